// File: doc/BRIEF.md
# Edge-Triggered Interrupt Mask and Status Unit

This block gathers ten event sources into a 16-bit pending register and a 16-bit enable register. Five counter output lines, three gate input lines, an error indication and a ready indication feed it. Every source passes through a synchronizer, and a rising edge is turned into a one-cycle event. The event is latched as a pending bit whether or not its enable bit is set. The enable register only decides which pending bits drive the two interrupt lines, the group line and the system line.

A byte-wide host bus reaches both registers. The enable halves are written at one pair of subaddresses and the pending halves are read at a different pair. A read returns one pending byte and clears exactly the bits it returned. Bus strobes go to a three-state controller:

- **ST_IDLE**: no command is being committed.
- **ST_WRITE**: a captured write is committed.
- **ST_READ**: a captured read is committed.

The controller's transitions are the same from every state. A strobe with write enable moves it to ST_WRITE (transition *take_write*). A strobe without write enable moves it to ST_READ (*take_read*). No strobe returns it to ST_IDLE (*go_idle*). A command sampled at one clock edge is therefore committed at the next edge, and back-to-back commands are accepted.

Top module: `irq_collect`

## Requirements
- R1: A synchronous active-high `rst` clears the pending and enable registers and `bus_rdata`, and drives both interrupt lines low.
- R2: The bit layout of both registers is fixed:
  - Counter output 1 to 5 sit at bits 7 down to 3.
  - Gate input 1 to 3 sit at bits 2 down to 0.
  - Ready sits at bit 15 and error at bit 14.
  - Bits 13 to 8 are always 0 in both registers.
- R3: A source that is sampled high at edge k after being low at edge k-1 sets its pending bit at edge k+2. A source held high sets the bit only once.
- R4: A rising edge sets its pending bit whatever the state of its enable bit.
- R5: `irq_group` and `irq_system` are both 1 exactly when the bitwise AND of the pending and enable registers is nonzero.
- R6: Enable register writes:
  - A write strobe at subaddress 4 stores `bus_wdata[7:6]` into enable bits 15:14.
  - A write strobe at subaddress 5 stores `bus_wdata` into enable bits 7:0.
  - The write takes effect at the edge after the strobe is sampled.
  - Writes to other subaddresses change nothing.
- R7: Pending register reads:
  - A read strobe at subaddress 0 returns pending bits 15:8 on `bus_rdata`.
  - A read strobe at subaddress 1 returns pending bits 7:0.
  - The byte appears at the edge after the strobe is sampled and is held until the next read.
  - A read at any other subaddress returns 0.
- R8: A read clears only the pending bits it returned. An event that arrives at the edge where the read commits stays set.
- R9: A falling edge on a source sets no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_out | input | N_CNT | Counter output lines, index 0 is counter 1 |
| gate_in | input | N_GATE | Gate input lines, index 0 is gate 1 |
| err_evt | input | 1 | Error indication source |
| rdy_evt | input | 1 | Ready indication source |
| bus_stb | input | 1 | Bus command strobe, one per command |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Subaddress |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Last read byte |
| irq_group | output | 1 | Group interrupt line |
| irq_system | output | 1 | System interrupt line |

## Verification
The bench builds the block with its defaults: five counter lines, three gate lines, a two-stage synchronizer and a 3-bit subaddress. With these values all ten sources fill the complete byte layout, so every bit position and both unused-bit rules can be reached. The fixed two-stage latency also lets the model place an event exactly on the edge where a clearing read commits. The reference model replays the source samples through a history queue and compares the read byte and both interrupt lines on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } bus_st_t;

    // subaddress map; pending reads and enable writes use different addresses
    localparam int SA_PEND_HI = 0;
    localparam int SA_PEND_LO = 1;
    localparam int SA_EN_HI   = 4;
    localparam int SA_EN_LO   = 5;

    localparam int REG_W   = 16;
    localparam int BIT_RDY = 15;
    localparam int BIT_ERR = 14;
    localparam int LO_MSB  = 7;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] rise
);
    logic [STAGES-1:0][W-1:0] chain_q;
    logic [W-1:0]             last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= '0;
        end else begin
            chain_q[0] <= raw;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            last_q <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output bus_st_t           state,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              wr_hi,
    output logic              wr_lo,
    output logic              rd_hi,
    output logic              rd_lo
);
    bus_st_t state_n;

    always_comb begin
        unique case ({stb, we})
            2'b11:   state_n = ST_WRITE;
            2'b10:   state_n = ST_READ;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else begin
            state <= state_n;
            if (stb) begin
                cmd_addr <= addr;
                cmd_data <= wdata;
            end
        end
    end

    always_comb begin
        wr_hi = 1'b0;
        wr_lo = 1'b0;
        rd_hi = 1'b0;
        rd_lo = 1'b0;
        unique case (state)
            ST_WRITE: begin
                wr_hi = (cmd_addr == ADDR_W'(SA_EN_HI));
                wr_lo = (cmd_addr == ADDR_W'(SA_EN_LO));
            end
            ST_READ: begin
                rd_hi = (cmd_addr == ADDR_W'(SA_PEND_HI));
                rd_lo = (cmd_addr == ADDR_W'(SA_PEND_LO));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_collect.sv
module irq_collect
    import irq_pkg::*;
#(
    parameter int N_CNT       = 5,
    parameter int N_GATE      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CNT-1:0]  cnt_out,
    input  logic [N_GATE-1:0] gate_in,
    input  logic              err_evt,
    input  logic              rdy_evt,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq_group,
    output logic              irq_system
);
    localparam int GATE_MSB = LO_MSB - N_CNT;
    localparam int UNUSED_W = BIT_ERR - 8;

    logic [REG_W-1:0]  raw_vec;
    logic [REG_W-1:0]  rise_vec;
    logic [REG_W-1:0]  status_q;
    logic [REG_W-1:0]  mask_q;
    logic [REG_W-1:0]  clr_vec;
    bus_st_t           fsm_state;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_data;
    logic              wr_hi, wr_lo, rd_hi, rd_lo;

    // source placement: counter 1 at bit 7 downward, gates after the counters
    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        assign raw_vec[LO_MSB-i] = cnt_out[i];
    end
    for (genvar j = 0; j < N_GATE; j++) begin : g_gate
        assign raw_vec[GATE_MSB-j] = gate_in[j];
    end
    assign raw_vec[BIT_RDY]    = rdy_evt;
    assign raw_vec[BIT_ERR]    = err_evt;
    assign raw_vec[BIT_ERR-1:8] = '0;

    irq_edge_sync #(
        .W      (REG_W),
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw_vec),
        .rise (rise_vec)
    );

    irq_bus_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .stb      (bus_stb),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .state    (fsm_state),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .rd_hi    (rd_hi),
        .rd_lo    (rd_lo)
    );

    always_comb begin
        clr_vec = '0;
        if (rd_hi) clr_vec[15:8] = status_q[15:8];
        if (rd_lo) clr_vec[7:0]  = status_q[7:0];
    end

    // pending bits: clear what was returned, then set new events on top
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_vec) | rise_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            if (wr_hi) mask_q[15:8] <= {cmd_data[7:6], {UNUSED_W{1'b0}}};
            if (wr_lo) mask_q[7:0]  <= cmd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (fsm_state == ST_READ) begin
            bus_rdata <= rd_hi ? status_q[15:8] :
                         rd_lo ? status_q[7:0]  : 8'h00;
        end
    end

    assign irq_group  = |(status_q & mask_q);
    assign irq_system = irq_group;
endmodule

// File: rtl/irq_collect_chk.sv
module irq_collect_chk
    import irq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input bus_st_t           state,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [7:0]        cmd_data,
    input logic [15:0]       status_q,
    input logic [15:0]       mask_q,
    input logic [15:0]       rise,
    input logic [7:0]        bus_rdata
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (status_q == 16'h0 && mask_q == 16'h0 && bus_rdata == 8'h0));

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (status_q[13:8] == 6'h0 && mask_q[13:8] == 6'h0));

    p_edge_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((status_q & $past(rise)) == $past(rise)));

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_WRITE) |=> $stable(mask_q));

    p_write_lo_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE && cmd_addr == ADDR_W'(SA_EN_LO)) |=> (mask_q[7:0] == $past(cmd_data)));

    p_read_lo_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ && cmd_addr == ADDR_W'(SA_PEND_LO)) |=> (bus_rdata == $past(status_q[7:0])));

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_READ) |=> ((status_q & $past(status_q)) == $past(status_q)));

    p_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READ && cmd_addr == ADDR_W'(SA_PEND_LO) && rise[7:0] == 8'h0) |=> (status_q[7:0] == 8'h0));
endmodule

bind irq_collect irq_collect_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (fsm_state),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .rise      (rise_vec),
    .bus_rdata (bus_rdata)
);

// File: tb/irq_collect_test.sv
module irq_collect_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] cnt_out = '0;
    logic [2:0] gate_in = '0;
    logic       err_evt = 1'b0, rdy_evt = 1'b0;
    logic       bus_stb = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_group, irq_system;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    irq_collect uut (
        .clk(clk), .rst(rst), .cnt_out(cnt_out), .gate_in(gate_in),
        .err_evt(err_evt), .rdy_evt(rdy_evt), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_group(irq_group), .irq_system(irq_system)
    );

    // ---------------- reference model ----------------
    logic [15:0] hist[$];
    logic [15:0] m_pend = '0, m_en = '0;
    logic [7:0]  m_rd = '0;
    bit          p_valid = 0, p_we = 0;
    logic [2:0]  p_addr = '0;
    logic [7:0]  p_data = '0;

    function automatic logic [15:0] pack_src();
        logic [15:0] v = '0;
        for (int i = 0; i < 5; i++) v[7-i] = cnt_out[i];
        for (int j = 0; j < 3; j++) v[2-j] = gate_in[j];
        v[15] = rdy_evt;
        v[14] = err_evt;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            m_pend = '0; m_en = '0; m_rd = '0; p_valid = 0;
        end else begin
            logic [15:0] ev, a, b, clr;
            hist.push_back(pack_src());
            a = (hist.size() >= 3) ? hist[hist.size()-3] : 16'h0;
            b = (hist.size() >= 4) ? hist[hist.size()-4] : 16'h0;
            ev = a & ~b;
            clr = '0;
            if (p_valid && !p_we) begin
                if (p_addr == 3'd0)      begin m_rd = m_pend[15:8]; clr[15:8] = m_pend[15:8]; end
                else if (p_addr == 3'd1) begin m_rd = m_pend[7:0];  clr[7:0]  = m_pend[7:0];  end
                else                     m_rd = 8'h00;
            end
            if (p_valid && p_we) begin
                if (p_addr == 3'd4) m_en[15:8] = {p_data[7:6], 6'b0};
                if (p_addr == 3'd5) m_en[7:0]  = p_data;
            end
            m_pend = (m_pend & ~clr) | ev;
            p_valid = bus_stb; p_we = bus_we; p_addr = bus_addr; p_data = bus_wdata;
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R7 rdata", {8'h0, bus_rdata}, {8'h0, m_rd});
            chk("R5 irq_group", {15'h0, irq_group}, {15'h0, |(m_pend & m_en)});
            chk("R5 irq_system", {15'h0, irq_system}, {15'h0, |(m_pend & m_en)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [2:0] a, logic [7:0] d);
        bus_stb = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_stb = 0; bus_we = 0;
        @(negedge clk);
    endtask

    task automatic bus_read(logic [2:0] a, output logic [7:0] v);
        bus_stb = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_stb = 0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        tick(3);
        rst = 0;
        tick(1);
        // R1 reset state
        chk("R1 irq_group", {15'h0, irq_group}, 16'h0);
        chk("R1 rdata", {8'h0, bus_rdata}, 16'h0);
        bus_read(3'd0, v); chk("R1 pend hi", {8'h0, v}, 16'h0);
        bus_read(3'd1, v); chk("R1 pend lo", {8'h0, v}, 16'h0);

        // R4 counter 1 edge latched with enable off, R2 at bit 7
        cnt_out[0] = 1; tick(1); cnt_out[0] = 0; tick(4);
        chk("R4 no irq while disabled", {15'h0, irq_group}, 16'h0);
        bus_read(3'd1, v); chk("R2 R4 counter1 bit7", {8'h0, v}, 16'h0080);
        bus_read(3'd1, v); chk("R8 cleared after read", {8'h0, v}, 16'h0);

        // R2 gate 1 at bit 2, counter 5 at bit 3
        gate_in[0] = 1; cnt_out[4] = 1; tick(1); gate_in[0] = 0; cnt_out[4] = 0; tick(4);
        bus_read(3'd1, v); chk("R2 gate1 counter5", {8'h0, v}, 16'h000C);

        // R6 R5 enable gate 3 then fire it
        bus_write(3'd5, 8'h01);
        gate_in[2] = 1; tick(1); gate_in[2] = 0; tick(4);
        chk("R5 irq asserted", {15'h0, irq_system}, 16'h1);
        bus_read(3'd1, v); chk("R2 gate3 bit0", {8'h0, v}, 16'h0001);
        tick(1);
        chk("R5 irq drops after clear", {15'h0, irq_group}, 16'h0);

        // R6 unmapped write ignored: counter 2 must not raise irq
        bus_write(3'd6, 8'hFF);
        cnt_out[1] = 1; tick(1); cnt_out[1] = 0; tick(4);
        chk("R6 unmapped write ignored", {15'h0, irq_group}, 16'h0);

        // R7 unmapped read returns 0 and leaves pending intact
        bus_read(3'd2, v); chk("R7 unmapped read", {8'h0, v}, 16'h0);
        bus_read(3'd1, v); chk("R7 counter2 bit6", {8'h0, v}, 16'h0040);

        // R2 high byte: ready bit 15, error bit 14, unused bits stay 0
        bus_write(3'd4, 8'hFF);
        rdy_evt = 1; err_evt = 1; tick(1); rdy_evt = 0; err_evt = 0; tick(4);
        chk("R5 irq from ready/error", {15'h0, irq_group}, 16'h1);
        bus_read(3'd0, v); chk("R2 high byte", {8'h0, v}, 16'h00C0);
        bus_write(3'd4, 8'h00);

        // R3 held level sets once; R9 falling edge sets nothing
        cnt_out[2] = 1; tick(5);
        bus_read(3'd1, v); chk("R3 counter3 bit5", {8'h0, v}, 16'h0020);
        tick(5);
        bus_read(3'd1, v); chk("R3 held level no re-set", {8'h0, v}, 16'h0);
        cnt_out[2] = 0; tick(5);
        bus_read(3'd1, v); chk("R9 falling edge ignored", {8'h0, v}, 16'h0);

        // R8 event on the commit edge survives the clearing read
        cnt_out[3] = 1; tick(1); cnt_out[3] = 0; tick(4);
        gate_in[1] = 1;
        tick(1);
        gate_in[1] = 0;
        bus_read(3'd1, v); chk("R8 read before same-edge event", {8'h0, v}, 16'h0010);
        bus_read(3'd1, v); chk("R8 same-edge event kept", {8'h0, v}, 16'h0002);

        // R1 reset in mid-run clears everything
        cnt_out[0] = 1; tick(1); cnt_out[0] = 0; tick(4);
        rst = 1; tick(2); rst = 0; tick(1);
        bus_read(3'd1, v); chk("R1 reset clears pending", {8'h0, v}, 16'h0);

        tick(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule